// File: doc/BRIEF.md
# CAN Controller Mode Sequencer

This block manages the operating mode of a CAN protocol engine. Software writes a control word through a simple write port. Setting both the freeze-enable bit and the halt bit asks the engine to freeze. The sequencer waits until the engine reports that no frame is in flight. It then tells the bit-time prescaler to stop. Only after the prescaler confirms that it has stopped does it raise the freeze acknowledge. Leaving freeze is the same process in reverse: the acknowledge stays high until the prescaler is running again. Low-power requests come from the module-disable bit or from the doze and stop inputs, and they put the sequencer into a low-power state in which freeze cannot be entered.

The block also owns a self-clearing soft reset. A register write or a chip-wide request sets the soft-reset bit. That bit starts a four-phase request/acknowledge handshake into the slower protocol clock domain, with two-flop synchronizers in each direction. The bit reads back as 1 until the acknowledge has returned. The soft reset clears the mode controls and the wake-up interrupt mask and returns the state machine to normal, but it keeps the module-disable bit.

States: NORMAL, FRZ_WAIT (freeze requested, frame still in flight), FRZ_STOP (prescaler told to stop, waiting for it to halt), FREEZE (acknowledged), THAW (request withdrawn, waiting for the prescaler to run) and LOW_POWER. Transitions: NORMAL→LOW_POWER and FRZ_WAIT→LOW_POWER on a low-power request, which takes priority. NORMAL→FRZ_WAIT on a freeze request. FRZ_WAIT→NORMAL when the request is withdrawn. FRZ_WAIT→FRZ_STOP when the busy input is low. FRZ_STOP→FREEZE when the prescaler-running input is low. FRZ_STOP→NORMAL when the request is withdrawn while the prescaler still runs. FREEZE→THAW when the request is withdrawn. THAW→NORMAL when the prescaler is running. LOW_POWER→NORMAL when the low-power request ends. Any state→NORMAL when a soft reset is accepted.

Top module: `can_mode_ctrl`

## Requirements
- R1: A freeze is requested only when control bit 1 (freeze enable) and bit 2 (halt) are both 1; either bit alone leaves presc_stop and freeze_ack low.
- R2: While bus_busy is high in FRZ_WAIT, presc_stop stays low; presc_stop rises on the edge after the block sees bus_busy low.
- R3: freeze_ack rises only on an edge where presc_stop is high and presc_run is low.
- R4: Once the request is withdrawn, presc_stop falls at the next edge; freeze_ack stays high until an edge where presc_run is high.
- R5: Control bit 0 (module disable), doze_req or stop_req moves NORMAL or FRZ_WAIT to LOW_POWER; while in LOW_POWER no freeze is entered.
- R6: not_ready (read bit 8) is high in FREEZE, THAW and LOW_POWER and low in all other states; freeze_ack is read bit 9.
- R7: Control bit 3 (receive-FIFO enable) takes a written value only when the write lands while freeze_ack is high; writes at other times leave it unchanged.
- R8: Writing 1 to bit 5 sets the soft-reset bit; it reads 1 while the reset is pending and clears itself without further writes.
- R9: An accepted soft reset clears control bits 1 to 4 and returns the state machine to NORMAL, while bit 0 keeps its value (or the value written in the same cycle).
- R10: A soft-reset request arriving in LOW_POWER is ignored and bit 5 stays 0.
- R11: glb_srst_req starts a soft reset exactly as a write of bit 5 does.
- R12: p_srst, in the protocol clock domain, goes high during every soft reset before the soft-reset bit clears.
- R13: When a soft reset is accepted in the same cycle as a write, the reset wins for bits 1 to 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register and sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset, clk domain |
| pclk | input | 1 | Protocol engine clock |
| prst_n | input | 1 | Asynchronous active-low reset, pclk domain |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word to write |
| rd_data | output | 32 | Control word readback with status bits 8 and 9 |
| glb_srst_req | input | 1 | Chip-wide soft-reset request |
| doze_req | input | 1 | Doze low-power request |
| stop_req | input | 1 | Stop low-power request |
| bus_busy | input | 1 | Frame transmission or reception in progress |
| presc_run | input | 1 | Bit-time prescaler is running |
| presc_stop | output | 1 | Request to stop the prescaler |
| freeze_ack | output | 1 | Freeze acknowledged |
| not_ready | output | 1 | Engine is in freeze or a low-power mode |
| rxfifo_en | output | 1 | Receive-FIFO enable setting |
| wake_irq_en | output | 1 | Wake-up interrupt mask |
| p_srst | output | 1 | Soft reset to the protocol engine, pclk domain |

## Verification
A soft-reset acceptance can fall in the same cycle as an ordinary register write, and it can also fall while the freeze sequence is partway through. The bench provokes this by driving glb_srst_req together with a write that sets halt, freeze enable and the wake mask, while the state machine sits in FRZ_STOP. On the next edge it expects the soft-reset bit to be set, bits 1 to 4 to read 0 and presc_stop to have dropped back to the NORMAL value. A second case pairs a soft-reset write with the module-disable bit. Here the bench expects the disable bit to survive and the handshake to complete even though the state machine has entered LOW_POWER.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;

    typedef enum logic [2:0] {
        ST_NORMAL    = 3'd0,
        ST_FRZ_WAIT  = 3'd1,
        ST_FRZ_STOP  = 3'd2,
        ST_FREEZE    = 3'd3,
        ST_THAW      = 3'd4,
        ST_LOW_POWER = 3'd5
    } mode_state_e;

    localparam int BIT_MDIS  = 0;
    localparam int BIT_FRZEN = 1;
    localparam int BIT_HALT  = 2;
    localparam int BIT_RFEN  = 3;
    localparam int BIT_WAKE  = 4;
    localparam int BIT_SRST  = 5;
    localparam int BIT_NRDY  = 8;
    localparam int BIT_FACK  = 9;

    typedef struct packed {
        logic wake_msk;
        logic rfen;
        logic halt;
        logic frz_en;
        logic mdis;
    } cfg_t;

endpackage

// File: rtl/can_bit_sync.sv
module can_bit_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    genvar i;
    generate
        for (i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[i] <= 1'b0;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/can_mode_fsm.sv
module can_mode_fsm
    import can_mode_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        frz_req,
    input  logic        lp_req,
    input  logic        bus_busy,
    input  logic        presc_run,
    input  logic        soft_clr,
    output mode_state_e state,
    output logic        presc_stop,
    output logic        freeze_ack,
    output logic        not_ready,
    output logic        in_low_power
);
    mode_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_NORMAL;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (soft_clr) begin
            state_d = ST_NORMAL;
        end else begin
            unique case (state_q)
                ST_NORMAL: begin
                    if (lp_req)       state_d = ST_LOW_POWER;
                    else if (frz_req) state_d = ST_FRZ_WAIT;
                end
                ST_FRZ_WAIT: begin
                    if (lp_req)         state_d = ST_LOW_POWER;
                    else if (!frz_req)  state_d = ST_NORMAL;
                    else if (!bus_busy) state_d = ST_FRZ_STOP;
                end
                ST_FRZ_STOP: begin
                    if (!presc_run)    state_d = ST_FREEZE;
                    else if (!frz_req) state_d = ST_NORMAL;
                end
                ST_FREEZE: begin
                    if (!frz_req) state_d = ST_THAW;
                end
                ST_THAW: begin
                    if (presc_run) state_d = ST_NORMAL;
                end
                ST_LOW_POWER: begin
                    if (!lp_req) state_d = ST_NORMAL;
                end
                default: state_d = ST_NORMAL;
            endcase
        end
    end

    always_comb begin
        presc_stop   = 1'b0;
        freeze_ack   = 1'b0;
        not_ready    = 1'b0;
        in_low_power = 1'b0;
        unique case (state_q)
            ST_NORMAL, ST_FRZ_WAIT: ;
            ST_FRZ_STOP: presc_stop = 1'b1;
            ST_FREEZE: begin
                presc_stop = 1'b1;
                freeze_ack = 1'b1;
                not_ready  = 1'b1;
            end
            ST_THAW: begin
                freeze_ack = 1'b1;
                not_ready  = 1'b1;
            end
            ST_LOW_POWER: begin
                not_ready    = 1'b1;
                in_low_power = 1'b1;
            end
            default: ;
        endcase
    end

    assign state = state_q;
endmodule

// File: rtl/can_cfg_regs.sv
module can_cfg_regs
    import can_mode_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              glb_srst_req,
    input  logic              in_freeze,
    input  logic              in_low_power,
    input  logic              srst_ack,
    output cfg_t              cfg,
    output logic              srst_flag,
    output logic              soft_clr
);
    cfg_t cfg_q;
    logic flag_q;
    logic srst_ask;

    assign srst_ask = (wr_en && wr_data[BIT_SRST]) || glb_srst_req;
    assign soft_clr = srst_ask && !flag_q && !srst_ack && !in_low_power;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (soft_clr) begin
            cfg_q.mdis     <= wr_en ? wr_data[BIT_MDIS] : cfg_q.mdis;
            cfg_q.frz_en   <= 1'b0;
            cfg_q.halt     <= 1'b0;
            cfg_q.rfen     <= 1'b0;
            cfg_q.wake_msk <= 1'b0;
        end else if (wr_en) begin
            cfg_q.mdis     <= wr_data[BIT_MDIS];
            cfg_q.frz_en   <= wr_data[BIT_FRZEN];
            cfg_q.halt     <= wr_data[BIT_HALT];
            cfg_q.wake_msk <= wr_data[BIT_WAKE];
            if (in_freeze) cfg_q.rfen <= wr_data[BIT_RFEN];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 flag_q <= 1'b0;
        else if (soft_clr)          flag_q <= 1'b1;
        else if (flag_q && srst_ack) flag_q <= 1'b0;
    end

    assign cfg       = cfg_q;
    assign srst_flag = flag_q;
endmodule

// File: rtl/can_srst_hs.sv
module can_srst_hs #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pclk,
    input  logic prst_n,
    input  logic req,
    output logic ack,
    output logic p_srst
);
    logic p_req_s;

    can_bit_sync #(.STAGES(STAGES)) u_req_sync (
        .clk   (pclk),
        .rst_n (prst_n),
        .d     (req),
        .q     (p_req_s)
    );

    assign p_srst = p_req_s;

    can_bit_sync #(.STAGES(STAGES)) u_ack_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (p_req_s),
        .q     (ack)
    );
endmodule

// File: rtl/can_mode_ctrl.sv
module can_mode_ctrl
    import can_mode_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pclk,
    input  logic              prst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              glb_srst_req,
    input  logic              doze_req,
    input  logic              stop_req,
    input  logic              bus_busy,
    input  logic              presc_run,
    output logic              presc_stop,
    output logic              freeze_ack,
    output logic              not_ready,
    output logic              rxfifo_en,
    output logic              wake_irq_en,
    output logic              p_srst
);
    cfg_t        cfg;
    mode_state_e state_q;
    logic        srst_flag;
    logic        srst_ack;
    logic        soft_clr;
    logic        in_low_power;
    logic        frz_req;
    logic        lp_req;

    assign frz_req = cfg.halt && cfg.frz_en;
    assign lp_req  = cfg.mdis || doze_req || stop_req;

    can_mode_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .frz_req      (frz_req),
        .lp_req       (lp_req),
        .bus_busy     (bus_busy),
        .presc_run    (presc_run),
        .soft_clr     (soft_clr),
        .state        (state_q),
        .presc_stop   (presc_stop),
        .freeze_ack   (freeze_ack),
        .not_ready    (not_ready),
        .in_low_power (in_low_power)
    );

    can_cfg_regs #(.DATA_W(DATA_W)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .glb_srst_req (glb_srst_req),
        .in_freeze    (freeze_ack),
        .in_low_power (in_low_power),
        .srst_ack     (srst_ack),
        .cfg          (cfg),
        .srst_flag    (srst_flag),
        .soft_clr     (soft_clr)
    );

    can_srst_hs #(.STAGES(SYNC_STAGES)) u_hs (
        .clk    (clk),
        .rst_n  (rst_n),
        .pclk   (pclk),
        .prst_n (prst_n),
        .req    (srst_flag),
        .ack    (srst_ack),
        .p_srst (p_srst)
    );

    always_comb begin
        rd_data            = '0;
        rd_data[BIT_MDIS]  = cfg.mdis;
        rd_data[BIT_FRZEN] = cfg.frz_en;
        rd_data[BIT_HALT]  = cfg.halt;
        rd_data[BIT_RFEN]  = cfg.rfen;
        rd_data[BIT_WAKE]  = cfg.wake_msk;
        rd_data[BIT_SRST]  = srst_flag;
        rd_data[BIT_NRDY]  = not_ready;
        rd_data[BIT_FACK]  = freeze_ack;
    end

    assign rxfifo_en   = cfg.rfen;
    assign wake_irq_en = cfg.wake_msk;
endmodule

// File: rtl/can_mode_chk.sv
module can_mode_chk
    import can_mode_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        bus_busy,
    input logic        presc_run,
    input logic        presc_stop,
    input logic        freeze_ack,
    input logic        not_ready,
    input logic        rxfifo_en,
    input logic        srst_flag,
    input mode_state_e state_q
);
    // R2
    stop_after_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(presc_stop) |-> $past(!bus_busy));

    // R3
    ack_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(freeze_ack) |-> ($past(presc_stop) && $past(!presc_run)));

    // R4
    ack_drop_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(freeze_ack) |-> $past(presc_run));

    // R6
    ack_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        freeze_ack |-> not_ready);

    // R7
    rfen_in_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rxfifo_en) |-> $past(freeze_ack));

    // R10
    srst_not_low_power_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(srst_flag) |-> $past(state_q != ST_LOW_POWER));
endmodule

bind can_mode_ctrl can_mode_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_busy   (bus_busy),
    .presc_run  (presc_run),
    .presc_stop (presc_stop),
    .freeze_ack (freeze_ack),
    .not_ready  (not_ready),
    .rxfifo_en  (rxfifo_en),
    .srst_flag  (srst_flag),
    .state_q    (state_q)
);

// File: tb/tb_can_mode_ctrl.sv
module tb_can_mode_ctrl;
    logic        clk = 1'b0;
    logic        pclk = 1'b0;
    logic        rst_n = 1'b0;
    logic        prst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        glb_srst_req = 1'b0;
    logic        doze_req = 1'b0;
    logic        stop_req = 1'b0;
    logic        bus_busy = 1'b0;
    logic        presc_run = 1'b1;
    logic        presc_stop, freeze_ack, not_ready, rxfifo_en, wake_irq_en, p_srst;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;
    always #7 pclk = ~pclk;

    can_mode_ctrl dut (
        .clk (clk), .rst_n (rst_n), .pclk (pclk), .prst_n (prst_n),
        .wr_en (wr_en), .wr_data (wr_data), .rd_data (rd_data),
        .glb_srst_req (glb_srst_req), .doze_req (doze_req), .stop_req (stop_req),
        .bus_busy (bus_busy), .presc_run (presc_run), .presc_stop (presc_stop),
        .freeze_ack (freeze_ack), .not_ready (not_ready), .rxfifo_en (rxfifo_en),
        .wake_irq_en (wake_irq_en), .p_srst (p_srst)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    typedef struct packed {
        logic       wr;
        logic [5:0] d;
        logic       busy;
        logic       prun;
        logic       eack;
        logic       enrdy;
        logic       epstop;
        logic       erfen;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 6'h06, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
        '{1'b0, 6'h00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
        '{1'b0, 6'h00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
        '{1'b0, 6'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
        '{1'b0, 6'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
        '{1'b0, 6'h00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0},
        '{1'b1, 6'h0E, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1},
        '{1'b1, 6'h0A, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1},
        '{1'b0, 6'h00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1},
        '{1'b0, 6'h00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1},
        '{1'b0, 6'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1},
        '{1'b1, 6'h02, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1},
        '{1'b1, 6'h04, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1},
        '{1'b0, 6'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1}
    };

    task automatic write_cycle(input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        wr_data = '0;
    endtask

    task automatic wait_srst_done(output bit saw_p, output bit cleared);
        saw_p = 1'b0;
        cleared = 1'b0;
        for (int k = 0; k < 60; k++) begin
            @(negedge clk);
            if (p_srst) saw_p = 1'b1;
            if (!rd_data[5]) begin
                cleared = 1'b1;
                break;
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        bit saw_p, cleared;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        prst_n = 1'b1;
        @(negedge clk);
        // Reset state: R6, R8
        chk("R6 reset not_ready", {31'd0, not_ready}, 32'd0);
        chk("R3 reset freeze_ack", {31'd0, freeze_ack}, 32'd0);
        chk("R8 reset readback", rd_data, 32'd0);
        chk("R12 reset p_srst", {31'd0, p_srst}, 32'd0);

        // Table walk: R1 R2 R3 R4 R6 R7
        for (int i = 0; i < NV; i++) begin
            wr_en = VECS[i].wr;
            wr_data = {26'd0, VECS[i].d};
            bus_busy = VECS[i].busy;
            presc_run = VECS[i].prun;
            @(negedge clk);
            chk($sformatf("R3/R4 vec%0d freeze_ack", i), {31'd0, freeze_ack}, {31'd0, VECS[i].eack});
            chk($sformatf("R6 vec%0d not_ready", i), {31'd0, not_ready}, {31'd0, VECS[i].enrdy});
            chk($sformatf("R2/R1 vec%0d presc_stop", i), {31'd0, presc_stop}, {31'd0, VECS[i].epstop});
            chk($sformatf("R7 vec%0d rxfifo_en", i), {31'd0, rxfifo_en}, {31'd0, VECS[i].erfen});
        end
        wr_en = 1'b0;
        wr_data = '0;

        // R5: doze enters LOW_POWER
        doze_req = 1'b1;
        @(negedge clk);
        chk("R5 doze not_ready", {31'd0, not_ready}, 32'd1);
        chk("R6 doze rd bit8", {31'd0, rd_data[8]}, 32'd1);

        // R5: freeze request while in LOW_POWER has no effect
        write_cycle(32'h06);
        repeat (2) @(negedge clk);
        chk("R5 no freeze in low power ack", {31'd0, freeze_ack}, 32'd0);
        chk("R5 no freeze in low power stop", {31'd0, presc_stop}, 32'd0);

        // R10: soft reset rejected in LOW_POWER
        write_cycle(32'h26);
        chk("R10 srst ignored", {31'd0, rd_data[5]}, 32'd0);
        chk("R10 halt kept", {29'd0, rd_data[2:0]}, 32'd6);

        // Leave low power; freeze sequence reaches FRZ_STOP
        doze_req = 1'b0;
        bus_busy = 1'b0;
        presc_run = 1'b1;
        repeat (3) @(negedge clk);
        chk("R5 exit low power", {31'd0, not_ready}, 32'd0);
        chk("R2 stop after exit", {31'd0, presc_stop}, 32'd1);

        // R11 R13 R9: global request with same-cycle write during FRZ_STOP
        wr_en = 1'b1;
        wr_data = 32'h16;
        glb_srst_req = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        wr_data = '0;
        glb_srst_req = 1'b0;
        chk("R11 global sets srst", {31'd0, rd_data[5]}, 32'd1);
        chk("R13 reset wins over write", {27'd0, rd_data[4:0]}, 32'd0);
        chk("R9 fsm back to normal", {31'd0, presc_stop}, 32'd0);
        chk("R9 wake mask cleared", {31'd0, wake_irq_en}, 32'd0);

        // R8 R12: handshake completes
        wait_srst_done(saw_p, cleared);
        chk("R8 srst self clears", {31'd0, cleared}, 32'd1);
        chk("R12 p_srst seen before clear", {31'd0, saw_p}, 32'd1);
        repeat (12) @(negedge clk);
        chk("R12 p_srst released", {31'd0, p_srst}, 32'd0);

        // R9 R8: module disable preserved across soft reset
        write_cycle(32'h21);
        chk("R8 write sets srst", {31'd0, rd_data[5]}, 32'd1);
        chk("R9 mdis kept", {31'd0, rd_data[0]}, 32'd1);
        wait_srst_done(saw_p, cleared);
        chk("R8 srst clears in low power", {31'd0, cleared}, 32'd1);
        chk("R9 mdis after reset", {31'd0, rd_data[0]}, 32'd1);
        chk("R5 mdis low power", {31'd0, not_ready}, 32'd1);
        write_cycle(32'h00);
        repeat (2) @(negedge clk);
        chk("R5 mdis released", {31'd0, not_ready}, 32'd0);

        // R1: freeze enable alone does not freeze
        write_cycle(32'h02);
        repeat (4) @(negedge clk);
        chk("R1 frz_en alone stop", {31'd0, presc_stop}, 32'd0);
        chk("R1 frz_en alone ack", {31'd0, freeze_ack}, 32'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule